// File: doc/BRIEF.md
# ADC Conversion Trigger and Result Controller

This block is the digital control side of a successive-approximation converter. Software writes a configuration word made of a 3-bit start code, an edge-polarity bit, a burst-mode bit and a channel number. The controller then issues one-cycle conversion requests to the analog converter. A request goes out at once, or on the chosen edge of one of six trigger inputs, or back to back in burst mode, where the channel number steps upward on its own.

Finished conversions arrive on a valid/ready result stream carrying a 10-bit value and a channel number. The controller always accepts them: `res_ready` is held high, and no back-pressure is ever applied, so a result is taken in every cycle in which `res_valid` is high. Each result is folded into a 32-bit data word together with a completion flag and an overrun flag. Reading that word clears both flags.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `rd_data` is all zeros and `conv_req` is low.
- R2: A configuration write with start code 1 and burst off raises `conv_req` for one cycle, in the cycle after the write. `conv_chan` then equals the written `cfg_chan`.
- R3: A configuration write with start code 0 and burst off, made while no conversion is in progress, issues no request.
- R4: Start codes 2 to 7 select `trig_in[code-2]`. With `cfg_fall`=0, a rising edge on the selected input raises `conv_req` three cycles after the input changes, on the latched channel. Edges on the other inputs and the opposite edge are ignored.
- R5: With `cfg_fall`=1, a falling edge on the selected input starts a conversion with the same latency, and a rising edge does not.
- R6: One cycle after a result is accepted, `rd_data` holds the result in bits 15:6, the channel in bits 26:24, OVERRUN in bit 30 and DONE (set to 1) in bit 31. All other bits read zero.
- R7: A cycle with `rd_en` or `cfg_wr` clears DONE on the next cycle. If a result is accepted in the same cycle, DONE stays set and the new result is shown.
- R8: A configuration write made while a conversion is in progress (a request has been issued and no result has come back) issues a new request in the next cycle, whatever its start code.
- R9: A write with burst on issues a request for channel 0 in the next cycle. After that, one request follows two cycles after each accepted result, with channels rising by one and wrapping from NUM_CH-1 to 0. Trigger inputs are ignored while burst is on.
- R10: In burst mode, a result accepted while DONE is already set and no read is made in that cycle sets OVERRUN. A read clears OVERRUN. Outside burst mode, overwriting an unread result leaves OVERRUN at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_start | input | 3 | Start code: 0 none, 1 now, 2..7 trigger input code-2 |
| cfg_fall | input | 1 | Trigger edge: 0 rising, 1 falling |
| cfg_burst | input | 1 | Burst mode enable |
| cfg_chan | input | CH_W | Channel for single conversions |
| trig_in | input | NUM_TRIG | Asynchronous trigger inputs |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | CH_W | Channel for the current request |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready, always 1 |
| res_data | input | RES_W | Conversion result |
| res_chan | input | CH_W | Channel of the result |
| rd_en | input | 1 | Data-word read strobe (clears flags) |
| rd_data | output | 32 | Global data word |

## Verification
A request caused by a write is due one cycle after the write cycle. A request from a trigger edge is due three cycles after the pin changes, because of the two synchronizer flops and the edge register. In burst mode, the next request is due two cycles after the cycle in which a result is presented. The data word and its flags change one cycle after a result, read or write. The driver tasks log each expected request with its exact due cycle, taken from a bench cycle counter. The monitor samples on the falling edge and flags a request that is missing at that cycle, or one that appears at any other cycle. Data-word checks are made on the falling edge after the cycle that updates the word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int START_W   = 3;
  localparam int WORD_W    = 32;
  localparam int RES_LSB   = 6;
  localparam int CH_LSB    = 24;
  localparam int OVR_BIT   = 30;
  localparam int DONE_BIT  = 31;
  localparam int TRIG_BASE = 2;

  localparam logic [START_W-1:0] START_IDLE = 3'd0;
  localparam logic [START_W-1:0] START_NOW  = 3'd1;

  typedef struct packed {
    logic [START_W-1:0] start;
    logic               fall;
    logic               burst;
  } cfg_t;
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int N      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] stage_q [STAGES];
  logic [N-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= pins;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= stage_q[STAGES-1];
  end

  assign rise = stage_q[STAGES-1] & ~prev_q;
  assign fall = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adc_req_gen.sv
module adc_req_gen
  import adc_seq_pkg::*;
#(
  parameter int NUM_TRIG = 6,
  parameter int CH_W     = 3,
  parameter int NUM_CH   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [START_W-1:0]  cfg_start,
  input  logic                cfg_fall,
  input  logic                cfg_burst,
  input  logic [CH_W-1:0]     cfg_chan,
  input  logic [NUM_TRIG-1:0] rise,
  input  logic [NUM_TRIG-1:0] fall,
  input  logic                res_valid,
  output logic                conv_req,
  output logic [CH_W-1:0]     conv_chan,
  output logic                burst_on,
  output logic                busy
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  cfg_t            cfg_q;
  logic [CH_W-1:0] chan_q;
  logic [CH_W-1:0] seq_ch_q;
  logic            busy_q;
  logic            trig_hit;
  logic            wr_go, seq_go, trig_go, req_d;
  logic [CH_W-1:0] chan_d;

  function automatic logic [CH_W-1:0] next_ch(input logic [CH_W-1:0] c);
    return (c == LAST_CH) ? '0 : c + 1'b1;
  endfunction

  always_comb begin
    trig_hit = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (cfg_q.start == START_W'(i + TRIG_BASE))
        trig_hit = cfg_q.fall ? fall[i] : rise[i];
    end
  end

  assign wr_go   = cfg_wr && (cfg_burst || busy_q || (cfg_start == START_NOW));
  assign seq_go  = !cfg_wr && cfg_q.burst && !busy_q;
  assign trig_go = !cfg_wr && !cfg_q.burst && trig_hit;
  assign req_d   = wr_go || seq_go || trig_go;

  always_comb begin
    if (cfg_wr)      chan_d = cfg_burst ? '0 : cfg_chan;
    else if (seq_go) chan_d = seq_ch_q;
    else             chan_d = chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '{start: START_IDLE, fall: 1'b0, burst: 1'b0};
      chan_q    <= '0;
      seq_ch_q  <= '0;
      busy_q    <= 1'b0;
      conv_req  <= 1'b0;
      conv_chan <= '0;
    end else begin
      conv_req <= req_d;
      if (req_d) conv_chan <= chan_d;
      if (cfg_wr) begin
        cfg_q    <= '{start: cfg_start, fall: cfg_fall, burst: cfg_burst};
        chan_q   <= cfg_chan;
        seq_ch_q <= next_ch('0);
      end else if (seq_go) begin
        seq_ch_q <= next_ch(seq_ch_q);
      end
      if (req_d) busy_q <= 1'b1;
      else if (res_valid) busy_q <= 1'b0;
    end
  end

  assign burst_on = cfg_q.burst;
  assign busy     = busy_q;
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic [CH_W-1:0]   res_chan,
  input  logic              rd_en,
  input  logic              cfg_wr,
  input  logic              burst_on,
  output logic [WORD_W-1:0] rd_data
);
  logic [RES_W-1:0] val_q;
  logic [CH_W-1:0]  ch_q;
  logic             done_q;
  logic             ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      ch_q   <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (res_valid) begin
        val_q <= res_data;
        ch_q  <= res_chan;
      end
      if (res_valid) done_q <= 1'b1;
      else if (rd_en || cfg_wr) done_q <= 1'b0;
      if (res_valid && burst_on && done_q && !rd_en) ovr_q <= 1'b1;
      else if (rd_en) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[RES_LSB +: RES_W] = val_q;
    rd_data[CH_LSB +: CH_W]   = ch_q;
    rd_data[OVR_BIT]          = ovr_q;
    rd_data[DONE_BIT]         = done_q;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_TRIG = 6,
  parameter int RES_W    = 10,
  parameter int CH_W     = 3,
  parameter int NUM_CH   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [START_W-1:0]  cfg_start,
  input  logic                cfg_fall,
  input  logic                cfg_burst,
  input  logic [CH_W-1:0]     cfg_chan,
  input  logic [NUM_TRIG-1:0] trig_in,
  output logic                conv_req,
  output logic [CH_W-1:0]     conv_chan,
  input  logic                res_valid,
  output logic                res_ready,
  input  logic [RES_W-1:0]    res_data,
  input  logic [CH_W-1:0]     res_chan,
  input  logic                rd_en,
  output logic [WORD_W-1:0]   rd_data
);
  logic [NUM_TRIG-1:0] rise_w, fall_w;
  logic                burst_w, busy_w;

  assign res_ready = 1'b1;

  adc_edge_sync #(.N(NUM_TRIG), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins(trig_in), .rise(rise_w), .fall(fall_w)
  );

  adc_req_gen #(.NUM_TRIG(NUM_TRIG), .CH_W(CH_W), .NUM_CH(NUM_CH)) u_req (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_start(cfg_start),
    .cfg_fall(cfg_fall), .cfg_burst(cfg_burst), .cfg_chan(cfg_chan),
    .rise(rise_w), .fall(fall_w), .res_valid(res_valid),
    .conv_req(conv_req), .conv_chan(conv_chan), .burst_on(burst_w), .busy(busy_w)
  );

  adc_result_reg #(.RES_W(RES_W), .CH_W(CH_W)) u_res (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .rd_en(rd_en), .cfg_wr(cfg_wr), .burst_on(burst_w),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [2:0]       cfg_start,
  input logic             cfg_burst,
  input logic [CH_W-1:0]  cfg_chan,
  input logic             conv_req,
  input logic [CH_W-1:0]  conv_chan,
  input logic             res_valid,
  input logic [RES_W-1:0] res_data,
  input logic             rd_en,
  input logic [RES_W-1:0] word_val,
  input logic             word_done,
  input logic             word_ovr,
  input logic             burst_on,
  input logic             busy
);
  assert_start_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_start == 3'd1 && !cfg_burst) |=> (conv_req && conv_chan == $past(cfg_chan)));

  assert_idle_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_start == 3'd0 && !cfg_burst && !busy) |=> !conv_req);

  assert_done_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (word_done && word_val == $past(res_data)));

  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || cfg_wr) && !res_valid) |=> !word_done);

  assert_busy_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && busy) |=> conv_req);

  assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on && res_valid && word_done && !rd_en) |=> word_ovr);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_start(cfg_start),
  .cfg_burst(cfg_burst), .cfg_chan(cfg_chan), .conv_req(conv_req),
  .conv_chan(conv_chan), .res_valid(res_valid), .res_data(res_data),
  .rd_en(rd_en), .word_val(rd_data[15:6]), .word_done(rd_data[31]),
  .word_ovr(rd_data[30]), .burst_on(burst_w), .busy(busy_w)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_fall = 1'b0, cfg_burst = 1'b0;
  logic [2:0] cfg_start = '0, cfg_chan = '0;
  logic [5:0] trig_in = '0;
  logic       conv_req, res_ready;
  logic [2:0] conv_chan;
  logic       res_valid = 1'b0, rd_en = 1'b0;
  logic [9:0] res_data = '0;
  logic [2:0] res_chan = '0;
  logic [31:0] rd_data;

  int total = 0, bad = 0, cyc = 0, req_seen = 0;
  int exp_cyc[$];
  int exp_ch[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_start(cfg_start),
    .cfg_fall(cfg_fall), .cfg_burst(cfg_burst), .cfg_chan(cfg_chan),
    .trig_in(trig_in), .conv_req(conv_req), .conv_chan(conv_chan),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_chan(res_chan), .rd_en(rd_en), .rd_data(rd_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 20000) begin
    bad = bad + 1; total = total + 1;
    $display("FAIL watchdog: actual cyc=%0d expected < 20000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Monitor: compares observed requests against the expected queue
  always @(negedge clk) if (rst_n) begin
    if (conv_req) begin
      req_seen = req_seen + 1;
      total = total + 1;
      if (exp_cyc.size() == 0 || exp_cyc[0] != cyc) begin
        bad = bad + 1;
        $display("FAIL unexpected request: actual cyc=%0d ch=%0d expected none", cyc, conv_chan);
      end else begin
        if (conv_chan != 3'(exp_ch[0])) begin
          bad = bad + 1;
          $display("FAIL %s chan: actual %0d expected %0d", exp_tag[0], conv_chan, exp_ch[0]);
        end
        void'(exp_cyc.pop_front()); void'(exp_ch.pop_front()); void'(exp_tag.pop_front());
      end
    end else if (exp_cyc.size() != 0 && exp_cyc[0] <= cyc) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL %s missing request: actual none at cyc=%0d expected cyc=%0d",
               exp_tag[0], cyc, exp_cyc[0]);
      void'(exp_cyc.pop_front()); void'(exp_ch.pop_front()); void'(exp_tag.pop_front());
    end
  end

  function automatic logic [31:0] mkword(input bit d, input bit o, input int ch, input int v);
    logic [31:0] w = '0;
    w[15:6] = 10'(v); w[26:24] = 3'(ch); w[30] = o; w[31] = d;
    return w;
  endfunction

  task automatic push(input int c, input int ch, input string tag);
    exp_cyc.push_back(c); exp_ch.push_back(ch); exp_tag.push_back(tag);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input int st, input bit fl, input bit bu, input int ch,
                    input bit expect_req, input string tag);
    @(negedge clk); #1;
    cfg_wr = 1'b1; cfg_start = 3'(st); cfg_fall = fl; cfg_burst = bu; cfg_chan = 3'(ch);
    if (expect_req) push(cyc + 1, bu ? 0 : ch, tag);
    @(negedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic pin(input int i, input bit v, input bit expect_req, input int ch,
                     input string tag);
    @(negedge clk); #1;
    trig_in[i] = v;
    if (expect_req) push(cyc + 3, ch, tag);
  endtask

  task automatic complete(input int v, input int ch, input bit seq_next, input int nch);
    @(negedge clk); #1;
    res_valid = 1'b1; res_data = 10'(v); res_chan = 3'(ch);
    if (seq_next) push(cyc + 2, nch, "R9");
    @(negedge clk); #1;
    res_valid = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); #1;
    rd_en = 1'b1;
    @(negedge clk); #1;
    rd_en = 1'b0;
  endtask

  initial begin
    int base;
    idle(3);
    check("R1 reset word", rd_data, 32'h0);
    check("R1 reset req", {31'b0, conv_req}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R2 immediate start
    wr(1, 0, 0, 5, 1, "R2");
    idle(2);
    complete(10'h155, 5, 0, 0);
    check("R6 word layout", rd_data, mkword(1, 0, 5, 10'h155));
    rd();
    check("R7 read clears done", rd_data, mkword(0, 0, 5, 10'h155));

    // R3 start code 0 issues nothing
    base = req_seen;
    wr(0, 0, 0, 3, 0, "R3");
    idle(6);
    check("R3 no request", 32'(req_seen - base), 32'd0);

    // R4 rising edge on trig_in[2] (start code 4)
    wr(4, 0, 0, 2, 0, "R4");
    idle(4);
    base = req_seen;
    pin(0, 1, 0, 0, "R4");
    idle(5);
    check("R4 other pin ignored", 32'(req_seen - base), 32'd0);
    pin(2, 1, 1, 2, "R4");
    idle(5);
    complete(10'h3FF, 2, 0, 0);
    check("R6 full-scale word", rd_data, mkword(1, 0, 2, 10'h3FF));
    base = req_seen;
    pin(2, 0, 0, 0, "R4");
    idle(5);
    check("R4 falling edge ignored", 32'(req_seen - base), 32'd0);
    pin(0, 0, 0, 0, "R4");
    idle(4);

    // R5 falling edge on trig_in[5] (start code 7)
    wr(7, 1, 0, 3, 0, "R5");
    idle(4);
    base = req_seen;
    pin(5, 1, 0, 0, "R5");
    idle(5);
    check("R5 rising edge ignored", 32'(req_seen - base), 32'd0);
    pin(5, 0, 1, 3, "R5");
    idle(5);
    complete(10'h001, 3, 0, 0);
    check("R10 non-burst overwrite keeps overrun 0", rd_data, mkword(1, 0, 3, 10'h001));

    // R8 write during conversion restarts
    wr(1, 0, 0, 1, 1, "R8");
    check("R7 write clears done", {31'b0, rd_data[31]}, 32'd0);
    wr(0, 0, 0, 6, 1, "R8");
    idle(2);
    complete(10'h2AA, 6, 0, 0);

    // R7 read coinciding with completion keeps done
    @(negedge clk); #1;
    res_valid = 1'b1; res_data = 10'h0F0; res_chan = 3'd6; rd_en = 1'b1;
    @(negedge clk); #1;
    res_valid = 1'b0; rd_en = 1'b0;
    check("R7 coincident read keeps done", rd_data, mkword(1, 0, 6, 10'h0F0));
    rd();

    // R9 burst sequence with wrap; R10 overrun
    wr(2, 0, 1, 0, 1, "R9");
    idle(3);
    pin(0, 1, 0, 0, "R9");
    idle(4);
    pin(0, 0, 0, 0, "R9");
    idle(4);
    for (int k = 1; k <= 9; k++) begin
      complete(k * 7, (k - 1) % 8, 1, k % 8);
      if (k == 1) check("R10 first burst result no overrun", rd_data, mkword(1, 0, 0, 7));
      if (k == 2) check("R10 overrun set", rd_data, mkword(1, 1, 1, 14));
      idle(3);
      if (k == 5) begin
        rd();
        check("R10 read clears overrun", rd_data, mkword(0, 0, 4, 35));
      end
    end
    wr(0, 0, 0, 4, 1, "R8");
    idle(2);
    complete(10'h111, 4, 0, 0);
    idle(4);
    total = total + 1;
    if (exp_cyc.size() != 0) begin
      bad = bad + 1;
      $display("FAIL R9 pending requests: actual %0d expected 0", exp_cyc.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule